// File: doc/BRIEF.md
# Serial Output Driver Mode Sensing

This block decides, after every reset, how a shared serial data output is to be driven. The output runs in a time-division frame of eight channels of 32 bits each, 256 data-clock bit periods in all, that starts at a rising edge of the frame sync. Each channel carries its bytes in the order B1, B2, monitor, then D plus C/I. In the first full frame after reset the block drives the line low for one bit period. That bit is the first bit of the monitor byte of the first channel that this device owns. The block then releases the line and samples it one bit later. A line that has come back high shows an external pull-up, and the block stays open-drain. A line that stays low selects push-pull drive.

The output changes on the rising edge of the data clock. The line is captured on the falling edge and passes through a two-flop synchronizer before the decision. A strap input chooses whether this device's line interfaces occupy frame channels 0 to 3 or 4 to 7. The same strap places the probe bit at position 16 or at position 144 of the frame. A small mapping output gives the frame channel of a chosen line interface.

The controller moves through the states IDLE, ARMED, PULL, RELEASE, SYNC1, SYNC2, OPEN and PUSH.
- IDLE to ARMED: on the first frame start.
- ARMED to PULL: at the bit before the probe bit.
- PULL to RELEASE, RELEASE to SYNC1, SYNC1 to SYNC2: one bit period each.
- SYNC2 to OPEN: on a synchronized high.
- SYNC2 to PUSH: on a synchronized low.
- ARMED, PULL, RELEASE, SYNC1 or SYNC2 on a frame start: the first time, the block returns to ARMED to retry. The second time, it falls back to OPEN.
- OPEN and PUSH: held until reset.

Top module: `serial_drive_sense`

## Requirements
- R1: While reset is low, drv_en, sense_done and push_pull are 0, and no clock edge is needed for this.
- R2: In the first frame after reset, drv_en=1 with drv_val=0 for exactly the one bit period at position 16 (strap=0) or 144 (strap=1), counting the frame-start period as position 0; before the decision drv_en is 0 in every other period.
- R3: The line level captured on the falling clock edge of the bit period after the probe bit decides the mode, and sense_done rises in the period four bit positions after the probe bit.
- R4: A high sample selects open-drain (push_pull=0): then drv_en = tx_en AND NOT tx_bit, and drv_val = 0.
- R5: A low sample selects push-pull (push_pull=1): then drv_en = tx_en and drv_val = tx_bit.
- R6: A frame-sync rising edge before the decision restarts the probe once, in the new frame. A second such edge ends sensing in open-drain mode with sense_done=1 in the next period.
- R7: Once sense_done is 1, it and push_pull hold their values until reset, whatever frame sync and the line do.
- R8: chan_out equals line_sel when strap=0 and line_sel+4 when strap=1.
- R9: Before the decision, tx_en and tx_bit have no effect on drv_en or drv_val.
- R10: Line levels in any period other than the sample period have no effect on the decided mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync; a rising edge starts a frame |
| strap | input | 1 | Channel offset select (0: channels 0-3, 1: channels 4-7) |
| line_in | input | 1 | Level seen on the shared serial line |
| tx_en | input | 1 | Request to transmit in the current bit |
| tx_bit | input | 1 | Data bit to transmit |
| line_sel | input | 2 | Line interface number to map |
| drv_en | output | 1 | Output driver enable (0 = high impedance) |
| drv_val | output | 1 | Level driven when drv_en is 1 |
| push_pull | output | 1 | 1 when push-pull mode was chosen |
| sense_done | output | 1 | 1 once the drive mode is decided |
| chan_out | output | 3 | Frame channel of line_sel |

## Verification
The hardest situations to reach from the ports are the retry and fallback paths. In both, a new frame sync must arrive while the probe is still pending. The bench cuts frames short at a chosen bit count, first once and then twice in a row, before the probe bit is reached. It then checks where the probe lands, or that open-drain mode appears at once. The other hard point is telling the sample bit apart from its neighbours. Random levels are driven on the line in every period except the sample period, so a decision taken one bit early or late shows up as a wrong mode.

// File: rtl/sds_pkg.sv
package sds_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_PULL,
        ST_RELEASE,
        ST_SYNC1,
        ST_SYNC2,
        ST_OPEN,
        ST_PUSH
    } sense_state_e;
endpackage

// File: rtl/sds_frame_timer.sv
module sds_frame_timer #(
    parameter int FRAME_BITS = 256,
    localparam int CW = $clog2(FRAME_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fsync,
    output logic          frame_start,
    output logic [CW-1:0] bit_pos
);
    logic fsync_q;

    assign frame_start = fsync & ~fsync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsync_q <= 1'b0;
            bit_pos <= '0;
        end else begin
            fsync_q <= fsync;
            if (frame_start)
                bit_pos <= '0;
            else if (bit_pos == CW'(FRAME_BITS - 1))
                bit_pos <= '0;
            else
                bit_pos <= bit_pos + 1'b1;
        end
    end
endmodule

// File: rtl/sds_line_sampler.sv
module sds_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_sync
);
    logic                   fall_smp;
    logic [SYNC_STAGES-1:0] sync_q;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fall_smp <= 1'b0;
        else        fall_smp <= line_in;
    end

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= fall_smp;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], fall_smp};
            end
        end
    endgenerate

    assign line_sync = sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/sds_chan_map.sv
module sds_chan_map #(
    parameter int CHANS = 8,
    parameter int LINES = 4,
    localparam int CHW = $clog2(CHANS),
    localparam int LW  = $clog2(LINES)
) (
    input  logic           strap,
    input  logic [LW-1:0]  line_sel,
    output logic [CHW-1:0] chan_out
);
    assign chan_out = CHW'(line_sel) + (strap ? CHW'(LINES) : '0);
endmodule

// File: rtl/serial_drive_sense.sv
module serial_drive_sense #(
    parameter int CHANS     = 8,
    parameter int CHAN_BITS = 32,
    parameter int MON_OFS   = 16,
    parameter int LINES     = 4,
    localparam int FRAME_BITS = CHANS * CHAN_BITS,
    localparam int CW  = $clog2(FRAME_BITS),
    localparam int CHW = $clog2(CHANS),
    localparam int LW  = $clog2(LINES)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fsync,
    input  logic           strap,
    input  logic           line_in,
    input  logic           tx_en,
    input  logic           tx_bit,
    input  logic [LW-1:0]  line_sel,
    output logic           drv_en,
    output logic           drv_val,
    output logic           push_pull,
    output logic           sense_done,
    output logic [CHW-1:0] chan_out
);
    import sds_pkg::*;

    localparam int PROBE_LO = MON_OFS;
    localparam int PROBE_HI = LINES * CHAN_BITS + MON_OFS;

    sense_state_e  state, state_nx;
    logic          frame_start;
    logic [CW-1:0] bit_pos;
    logic [CW-1:0] probe_pos;
    logic          line_sync;
    logic          retried;
    logic          abort;

    sds_frame_timer #(.FRAME_BITS(FRAME_BITS)) i_timer (
        .clk(clk), .rst_n(rst_n), .fsync(fsync),
        .frame_start(frame_start), .bit_pos(bit_pos)
    );

    sds_line_sampler #(.SYNC_STAGES(2)) i_sampler (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .line_sync(line_sync)
    );

    sds_chan_map #(.CHANS(CHANS), .LINES(LINES)) i_map (
        .strap(strap), .line_sel(line_sel), .chan_out(chan_out)
    );

    assign probe_pos = strap ? CW'(PROBE_HI) : CW'(PROBE_LO);

    assign abort = frame_start &&
                   (state == ST_ARMED || state == ST_PULL || state == ST_RELEASE ||
                    state == ST_SYNC1 || state == ST_SYNC2);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (frame_start) state_nx = ST_ARMED;
            ST_ARMED:   if (abort) state_nx = retried ? ST_OPEN : ST_ARMED;
                        else if (bit_pos == probe_pos - 1'b1) state_nx = ST_PULL;
            ST_PULL:    state_nx = abort ? (retried ? ST_OPEN : ST_ARMED) : ST_RELEASE;
            ST_RELEASE: state_nx = abort ? (retried ? ST_OPEN : ST_ARMED) : ST_SYNC1;
            ST_SYNC1:   state_nx = abort ? (retried ? ST_OPEN : ST_ARMED) : ST_SYNC2;
            ST_SYNC2:   if (abort) state_nx = retried ? ST_OPEN : ST_ARMED;
                        else state_nx = line_sync ? ST_OPEN : ST_PUSH;
            ST_OPEN:    state_nx = ST_OPEN;
            ST_PUSH:    state_nx = ST_PUSH;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            retried <= 1'b0;
        end else begin
            state <= state_nx;
            if (abort) retried <= 1'b1;
        end
    end

    always_comb begin
        drv_en     = 1'b0;
        drv_val    = 1'b0;
        sense_done = 1'b0;
        push_pull  = 1'b0;
        unique case (state)
            ST_PULL: begin
                drv_en  = 1'b1;
                drv_val = 1'b0;
            end
            ST_OPEN: begin
                sense_done = 1'b1;
                drv_en     = tx_en & ~tx_bit;
            end
            ST_PUSH: begin
                sense_done = 1'b1;
                push_pull  = 1'b1;
                drv_en     = tx_en;
                drv_val    = tx_bit;
            end
            default: ;
        endcase
    end

    // R2
    probe_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sense_done && drv_en) |-> !drv_val);
    // R2
    probe_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PULL) |-> (bit_pos == probe_pos));
    // R2
    single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PULL) |=> !drv_en);
    // R3
    decide_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SYNC2 && !frame_start && line_sync) |=> (sense_done && !push_pull));
    // R4
    od_no_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_done && !push_pull) |-> !(drv_en && drv_val));
    // R7
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sense_done |=> (sense_done && $stable(push_pull)));
endmodule

// File: tb/test_serial_drive_sense.sv
`timescale 1ns/1ps
module test_serial_drive_sense;
    logic clk = 1'b0;
    logic rst_n, fsync, strap, line_in, tx_en, tx_bit;
    logic [1:0] line_sel;
    logic drv_en, drv_val, push_pull, sense_done;
    logic [2:0] chan_out;
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    serial_drive_sense i_serial_drive_sense (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .strap(strap),
        .line_in(line_in), .tx_en(tx_en), .tx_bit(tx_bit), .line_sel(line_sel),
        .drv_en(drv_en), .drv_val(drv_val), .push_pull(push_pull),
        .sense_done(sense_done), .chan_out(chan_out)
    );

    function automatic int probe_at(bit s);
        return s ? 4 * 32 + 16 : 16;
    endfunction

    function automatic bit exp_en(bit done, bit pp, bit probe, bit te, bit tb);
        if (!done) return probe;
        return pp ? te : (te & ~tb);
    endfunction

    function automatic bit exp_val(bit done, bit pp, bit tb);
        return done & pp & tb;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic do_reset(bit s);
        rst_n = 1'b0; fsync = 1'b0; strap = s; line_in = 1'b0;
        tx_en = 1'b0; tx_bit = 1'b0; line_sel = 2'd0;
        #12;
        chk(drv_en == 0, "R1", "drv_en in reset", drv_en, 0);
        chk(sense_done == 0, "R1", "sense_done in reset", sense_done, 0);
        chk(push_pull == 0, "R1", "push_pull in reset", push_pull, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
    endtask

    // Starts at #1 after an edge with fsync just raised; period k follows edge k.
    task automatic run_frame(int upto, bit samp, bit s);
        int p = probe_at(s);
        for (int k = 0; k <= upto; k++) begin
            bit done_e, pp_e;
            @(posedge clk); #1;
            if (k == 2) fsync = 1'b0;
            line_in = (k == p + 1) ? samp : 1'($urandom);
            tx_en = 1'($urandom); tx_bit = 1'($urandom);
            #1;
            done_e = (k >= p + 4);
            pp_e = done_e & ~samp;
            chk(drv_en == exp_en(done_e, pp_e, k == p, tx_en, tx_bit), "R2", "drv_en", drv_en,
                exp_en(done_e, pp_e, k == p, tx_en, tx_bit));
            chk(drv_val == exp_val(done_e, pp_e, tx_bit), "R9", "drv_val", drv_val,
                exp_val(done_e, pp_e, tx_bit));
            chk(sense_done == done_e, "R3", "sense_done", sense_done, done_e);
            chk(push_pull == pp_e, samp ? "R4" : "R5", "push_pull", push_pull, pp_e);
        end
    endtask

    task automatic data_phase(int n, bit pp_e);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
            fsync = ($urandom % 6 == 0);
            line_in = 1'($urandom);
            tx_en = 1'($urandom); tx_bit = 1'($urandom);
            line_sel = 2'($urandom);
            #1;
            chk(sense_done == 1, "R7", "sense_done held", sense_done, 1);
            chk(push_pull == pp_e, "R7", "push_pull held", push_pull, pp_e);
            chk(drv_en == exp_en(1, pp_e, 0, tx_en, tx_bit), pp_e ? "R5" : "R4", "drv_en data",
                drv_en, exp_en(1, pp_e, 0, tx_en, tx_bit));
            chk(drv_val == exp_val(1, pp_e, tx_bit), pp_e ? "R5" : "R4", "drv_val data",
                drv_val, exp_val(1, pp_e, tx_bit));
            chk(chan_out == 3'(line_sel) + (strap ? 3'd4 : 3'd0), "R8", "chan_out",
                chan_out, 3'(line_sel) + (strap ? 3'd4 : 3'd0));
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        // R1 / R2: no frame sync means no probe
        do_reset(1'b0);
        for (int k = 0; k < 20; k++) begin
            @(posedge clk); #1; tx_en = 1'b1; tx_bit = 1'($urandom); #1;
            chk(drv_en == 0, "R2", "idle without frame", drv_en, 0);
            chk(sense_done == 0, "R1", "idle done", sense_done, 0);
        end
        // Directed corners, then random strap and sample (R10 via random line noise)
        for (int it = 0; it < 10; it++) begin
            bit s, smp;
            s   = (it < 4) ? it[1] : 1'($urandom);
            smp = (it < 4) ? it[0] : 1'($urandom);
            do_reset(s);
            fsync = 1'b1;
            run_frame(probe_at(s) + 8, smp, s);
            data_phase(30, ~smp);
        end
        // R6: one interrupted frame, probe retried in next frame
        for (int s = 0; s < 2; s++) begin
            do_reset(1'(s));
            fsync = 1'b1;
            run_frame(9, 1'b0, 1'(s));
            fsync = 1'b1;
            run_frame(probe_at(1'(s)) + 8, 1'(s), 1'(s));
            data_phase(10, ~1'(s));
        end
        // R6: two interrupted frames fall back to open-drain
        do_reset(1'b0);
        fsync = 1'b1;
        run_frame(9, 1'b0, 1'b0);
        fsync = 1'b1;
        run_frame(9, 1'b0, 1'b0);
        fsync = 1'b1;
        @(posedge clk); #2;
        chk(sense_done == 1, "R6", "fallback done", sense_done, 1);
        chk(push_pull == 0, "R6", "fallback open-drain", push_pull, 0);
        data_phase(20, 1'b0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #500000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule